// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a register-driven MDIO master. It generates the MDC management clock and drives a shared, released-when-idle MDIO data line so that software can reach PHY registers. One register set serves both frame styles. A mode bit selects the style: with the bit clear every frame is a Clause 22 frame, and with it set every frame is a Clause 45 frame. Software never writes a "go" bit. A frame begins as a side effect of the register write that supplies its last operand. Writing the data word sends a write frame. Writing the control word with its read command bit set sends a read frame. In Clause 45 mode, writing the address word sends an address frame.

Each frame is an optional 32-bit preamble of ones, followed by a 32-bit body. The body holds a 2-bit start code, a 2-bit opcode, the 5-bit PHY address, the 5-bit register or device number, a 2-bit turnaround and 16 data bits. The master changes MDIO only when MDC falls and samples it when MDC rises. For a read it releases the line for the turnaround and the data bits. A busy flag covers the whole frame, and a read-error flag records a PHY that did not pull the second turnaround bit low. MDC runs only during a frame. Its period is 2 x divider + 1 input clocks.

The frame engine is a state machine with these states:
- ST_IDLE: waiting for a start.
- ST_PREAMBLE: the ones are being sent.
- ST_HEADER: start code, opcode and the two addresses are being sent.
- ST_TURN: the turnaround bits.
- ST_DATA: the 16 data bits.
- ST_DONE: a single cycle that ends the frame.

The transitions are:
- ST_IDLE to ST_PREAMBLE on a start with the preamble enabled.
- ST_IDLE to ST_HEADER on a start with the preamble disabled.
- ST_PREAMBLE to ST_HEADER on the falling MDC edge after the last preamble bit.
- ST_HEADER to ST_TURN on the falling MDC edge after the register/device bits.
- ST_TURN to ST_DATA on the falling MDC edge after the second turnaround bit.
- ST_DATA to ST_DONE on the falling MDC edge after the last data bit.
- ST_DONE to ST_IDLE unconditionally.

Top module: `mdio_master`

## Requirements
- R1: Register words are selected by `reg_sel`: 0 = status/config, 1 = control, 2 = data, 3 = address. Status bit 0 is busy and bit 1 is read error; both are read-only. Status bit 5 disables the preamble, bit 6 selects Clause 45, and bits 15:7 hold the MDC divider. Control bits 4:0 hold the register (Clause 22) or device (Clause 45) number and bits 9:5 the PHY address; bit 15 is a read command that reads back as 0. The data and address words keep their low 16 bits. Unused bits read 0. After reset, status reads 0x280 (divider 5) and the other words read 0.
- R2: In Clause 22 mode, writing the data word sends a frame with start 01, opcode 01, the stored PHY and register numbers, turnaround 10 and the written 16-bit value.
- R3: In Clause 22 mode, writing the control word with bit 15 set sends a frame with start 01, opcode 10 and the written PHY and register numbers. The 16 data bits sampled from the PHY then read back from the data word.
- R4: In Clause 45 mode, writing the address word sends a frame with start 00, opcode 00, turnaround 10 and the written 16-bit address. In Clause 22 mode the same write only stores the value and starts no frame.
- R5: In Clause 45 mode, a data-word write sends start 00, opcode 01, and a control write with bit 15 set sends start 00, opcode 11 and captures the read data.
- R6: Busy is set from the cycle after the starting write until the frame ends. While busy, every register write is ignored: it neither changes stored values nor starts a frame.
- R7: If MDIO is not low when sampled at the second turnaround bit of a read, the read-error flag is set. A missing PHY therefore reads 0xFFFF. The flag clears when the next frame starts.
- R8: MDC has a period of 2 x divider + 1 input clocks, with a high phase of divider clocks. MDC stays low whenever the master is not busy.
- R9: With the preamble disable bit set, the frame starts directly with the start code and no preamble ones are sent. With the bit clear, exactly 32 ones come first.
- R10: The master changes MDIO only on a falling MDC edge. It drives the line for the whole of a write or address frame. For a read it releases the line (`mdio_oe` low) from the first turnaround bit to the end, and it never drives while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, from which MDC is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe (one cycle) |
| reg_sel | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_in | input | 1 | Resolved MDIO line value |

## Verification
A bench PHY decodes every frame from the line and checks it against expected frames queued by the register driver. It receives Clause 22 writes and reads, and Clause 45 address, write and read frames, each with distinct PHY and register numbers and data values. This shows that start codes, opcodes and field positions are not swapped between modes or operations. The same operations are repeated with the preamble disabled, and a read is made with the PHY absent, so the released line floats high. This separates a correct preamble count and correct turnaround handling from a master that always sends ones or ignores the turnaround. An address write in Clause 22 mode, control writes made during a frame, and a changed divider with a measured MDC phase complete the set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } eng_state_t;

    // Register word selects
    localparam logic [1:0] WORD_STATUS = 2'd0;
    localparam logic [1:0] WORD_CTRL   = 2'd1;
    localparam logic [1:0] WORD_DATA   = 2'd2;
    localparam logic [1:0] WORD_ADDR   = 2'd3;

    // Status field positions (decoded by software)
    localparam int BIT_BUSY    = 0;
    localparam int BIT_RDERR   = 1;
    localparam int BIT_NOPRE   = 5;
    localparam int BIT_C45     = 6;
    localparam int DIV_LSB     = 7;

    // Control field positions
    localparam int CTRL_REG_LSB = 0;
    localparam int CTRL_PHY_LSB = 5;
    localparam int BIT_RDCMD    = 15;

    // Frame geometry
    localparam int ADR_W    = 5;
    localparam int VAL_W    = 16;
    localparam int BODY_W   = 32;
    localparam int PRE_W    = 32;

    // Opcodes
    localparam logic [1:0] OP22_WR   = 2'b01;
    localparam logic [1:0] OP22_RD   = 2'b10;
    localparam logic [1:0] OP45_ADR  = 2'b00;
    localparam logic [1:0] OP45_WR   = 2'b01;
    localparam logic [1:0] OP45_RD   = 2'b11;

    // Start code, opcode, PHY, reg/dev, turnaround 10, payload
    function automatic logic [BODY_W-1:0] pack_body(
        input logic              c45,
        input logic [1:0]        op,
        input logic [ADR_W-1:0]  phy,
        input logic [ADR_W-1:0]  dev,
        input logic [VAL_W-1:0]  payload
    );
        logic [1:0] st;
        st = c45 ? 2'b00 : 2'b01;
        return {st, op, phy, dev, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_cnt;
    logic [CNT_W-1:0] full_cnt;
    logic             mdc_q;

    assign half_cnt  = {1'b0, div};
    assign full_cnt  = {div, 1'b0};
    assign rise_tick = en && (cnt_q == half_cnt);
    assign fall_tick = en && (cnt_q == full_cnt);
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            cnt_q <= fall_tick ? '0 : cnt_q + 1'b1;
            if (rise_tick)
                mdc_q <= 1'b1;
            else if (fall_tick)
                mdc_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 9,
    parameter int DIV_RESET = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              rd_err,
    input  logic              rd_done,
    input  logic [VAL_W-1:0]  rd_value,
    output logic              start,
    output logic [BODY_W-1:0] start_body,
    output logic              start_read,
    output logic              start_nopre,
    output logic [DIV_W-1:0]  div
);
    logic [DIV_W-1:0] div_q;
    logic             c45_q;
    logic             nopre_q;
    logic [ADR_W-1:0] phy_q;
    logic [ADR_W-1:0] dev_q;
    logic [VAL_W-1:0] data_q;
    logic [VAL_W-1:0] addr_q;
    logic             wr_ok;

    logic [ADR_W-1:0] w_phy;
    logic [ADR_W-1:0] w_dev;
    logic [VAL_W-1:0] w_val;
    logic [DIV_W-1:0] w_div;
    logic             unused_wbits;

    assign wr_ok = reg_wr && !busy;
    assign w_phy = reg_wdata[CTRL_PHY_LSB +: ADR_W];
    assign w_dev = reg_wdata[CTRL_REG_LSB +: ADR_W];
    assign w_val = reg_wdata[VAL_W-1:0];
    assign w_div = reg_wdata[DIV_LSB +: DIV_W];
    assign unused_wbits = ^{reg_wdata[31:VAL_W], reg_wdata[14:10], reg_wdata[4:2]};

    assign div         = div_q;
    assign start_nopre = nopre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(DIV_RESET);
            c45_q   <= 1'b0;
            nopre_q <= 1'b0;
            phy_q   <= '0;
            dev_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (wr_ok) begin
                unique case (reg_sel)
                    WORD_STATUS: begin
                        div_q   <= w_div;
                        c45_q   <= reg_wdata[BIT_C45];
                        nopre_q <= reg_wdata[BIT_NOPRE];
                    end
                    WORD_CTRL: begin
                        phy_q <= w_phy;
                        dev_q <= w_dev;
                    end
                    WORD_DATA: data_q <= w_val;
                    WORD_ADDR: addr_q <= w_val;
                endcase
            end
            if (rd_done)
                data_q <= rd_value;
        end
    end

    // Frame launch decode
    always_comb begin
        start      = 1'b0;
        start_read = 1'b0;
        start_body = '0;
        if (wr_ok) begin
            unique case (reg_sel)
                WORD_CTRL: begin
                    if (reg_wdata[BIT_RDCMD]) begin
                        start      = 1'b1;
                        start_read = 1'b1;
                        start_body = pack_body(c45_q, c45_q ? OP45_RD : OP22_RD,
                                               w_phy, w_dev, '1);
                    end
                end
                WORD_DATA: begin
                    start      = 1'b1;
                    start_body = pack_body(c45_q, c45_q ? OP45_WR : OP22_WR,
                                           phy_q, dev_q, w_val);
                end
                WORD_ADDR: begin
                    if (c45_q) begin
                        start      = 1'b1;
                        start_body = pack_body(1'b1, OP45_ADR, phy_q, dev_q, w_val);
                    end
                end
                default: ;
            endcase
        end
    end

    // Read-back mux
    always_comb begin
        unique case (reg_sel)
            WORD_STATUS: begin
                reg_rdata                 = 32'(div_q) << DIV_LSB;
                reg_rdata[BIT_C45]        = c45_q;
                reg_rdata[BIT_NOPRE]      = nopre_q;
                reg_rdata[BIT_RDERR]      = rd_err;
                reg_rdata[BIT_BUSY]       = busy;
            end
            WORD_CTRL: reg_rdata = 32'({phy_q, dev_q});
            WORD_DATA: reg_rdata = 32'(data_q);
            WORD_ADDR: reg_rdata = 32'(addr_q);
        endcase
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BODY_W-1:0] start_body,
    input  logic              start_read,
    input  logic              start_nopre,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              busy,
    output logic              clk_en,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rd_err,
    output logic              rd_done,
    output logic [VAL_W-1:0]  rd_value
);
    localparam int TOT_W   = PRE_W + BODY_W;
    localparam int IDX_W   = $clog2(TOT_W);
    localparam int SEL_W   = $clog2(BODY_W);
    localparam logic [IDX_W-1:0] IDX_FULL   = IDX_W'(TOT_W - 1);
    localparam logic [IDX_W-1:0] IDX_BODY   = IDX_W'(BODY_W - 1);
    localparam logic [IDX_W-1:0] IDX_PRE_LO = IDX_W'(BODY_W);
    localparam logic [IDX_W-1:0] IDX_HDR_LO = IDX_W'(VAL_W + 2);
    localparam logic [IDX_W-1:0] IDX_TA_LO  = IDX_W'(VAL_W);

    eng_state_t        state_q, state_d;
    logic [BODY_W-1:0] body_q;
    logic [IDX_W-1:0]  idx_q;
    logic              read_q;
    logic              err_q;
    logic [VAL_W-1:0]  shift_q;
    logic              last_fall;
    logic              cur_bit;

    assign last_fall = fall_tick && (state_q == ST_DATA) && (idx_q == '0);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = start_nopre ? ST_HEADER : ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && idx_q == IDX_PRE_LO) state_d = ST_HEADER;
            ST_HEADER:   if (fall_tick && idx_q == IDX_HDR_LO) state_d = ST_TURN;
            ST_TURN:     if (fall_tick && idx_q == IDX_TA_LO)  state_d = ST_DATA;
            ST_DATA:     if (last_fall) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q  <= '0;
            idx_q   <= '0;
            read_q  <= 1'b0;
            err_q   <= 1'b0;
            shift_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                body_q <= start_body;
                idx_q  <= start_nopre ? IDX_BODY : IDX_FULL;
                read_q <= start_read;
                err_q  <= 1'b0;
            end
        end else begin
            if (fall_tick && clk_en && !last_fall)
                idx_q <= idx_q - 1'b1;
            if (rise_tick && read_q) begin
                if (state_q == ST_TURN && idx_q == IDX_TA_LO && mdio_in)
                    err_q <= 1'b1;
                if (state_q == ST_DATA)
                    shift_q <= {shift_q[VAL_W-2:0], mdio_in};
            end
        end
    end

    assign cur_bit = (idx_q >= IDX_PRE_LO) ? 1'b1 : body_q[idx_q[SEL_W-1:0]];

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        clk_en  = 1'b0;
        mdio_oe = 1'b0;
        rd_done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PREAMBLE, ST_HEADER: begin
                clk_en  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                clk_en  = 1'b1;
                mdio_oe = !read_q;
            end
            ST_DONE: rd_done = read_q;
            default: ;
        endcase
        mdio_out = mdio_oe && cur_bit;
    end

    assign rd_err   = err_q;
    assign rd_value = shift_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 9,
    parameter int DIV_RESET = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic              busy_w;
    logic              rd_err_w;
    logic              rd_done_w;
    logic [VAL_W-1:0]  rd_value_w;
    logic              start_w;
    logic [BODY_W-1:0] body_w;
    logic              read_w;
    logic              nopre_w;
    logic [DIV_W-1:0]  div_w;
    logic              clk_en_w;
    logic              rise_w;
    logic              fall_w;

    mdio_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .rd_err(rd_err_w), .rd_done(rd_done_w), .rd_value(rd_value_w),
        .start(start_w), .start_body(body_w), .start_read(read_w),
        .start_nopre(nopre_w), .div(div_w)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(clk_en_w), .div(div_w),
        .mdc(mdc), .rise_tick(rise_w), .fall_tick(fall_w)
    );

    mdio_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .start_body(body_w), .start_read(read_w), .start_nopre(nopre_w),
        .rise_tick(rise_w), .fall_tick(fall_w), .mdio_in(mdio_in),
        .busy(busy_w), .clk_en(clk_en_w), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .rd_err(rd_err_w), .rd_done(rd_done_w), .rd_value(rd_value_w)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        rd_err,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata
);
    // R8: clock parked low outside frames
    a_r8_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R10: driven value only moves with a falling MDC
    a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_out != $past(mdio_out)))
            |-> ($past(mdc) && !mdc));

    // R10: never drives while idle
    a_r10_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R6: data write launches a frame
    a_r6_data_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == WORD_DATA && !busy) |=> busy);

    // R6: read command launches a frame
    a_r6_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == WORD_CTRL && reg_wdata[BIT_RDCMD] && !busy) |=> busy);

    // R7: error flag only rises inside a frame
    a_r7_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_err(rd_err_w),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        phy_oe = 1'b0;
    logic        phy_o = 1'b0;
    logic        rsp_en = 1'b1;
    logic        line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign line = mdio_oe ? mdio_out : (phy_oe ? phy_o : 1'b1);

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(line)
    );

    typedef struct {
        string       req;
        int          ones;
        logic [31:0] body;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] d);
        return {p, d, 6'h2B} ^ 16'hA5C3;
    endfunction

    function automatic logic [31:0] body(input bit c45, input logic [1:0] op,
                                         input logic [4:0] p, input logic [4:0] d,
                                         input logic [1:0] ta, input logic [15:0] v);
        return {(c45 ? 2'b00 : 2'b01), op, p, d, ta, v};
    endfunction

    // Bench PHY and scoreboard monitor
    int          pos = 0;
    int          ones = 0;
    logic [31:0] sh = '0;
    bit          is_rd = 0;
    bit          oe_bad = 0;
    logic [15:0] rsp_data = '0;

    always @(posedge mdc) begin
        bit exp_oe;
        exp_oe = !(is_rd && pos >= 14);
        if (mdio_oe != exp_oe) oe_bad = 1;
        if (pos == 0) begin
            if (line == 1'b0) begin
                sh  = 32'd0;
                pos = 1;
            end else begin
                ones++;
            end
        end else begin
            sh  = {sh[30:0], line};
            pos++;
        end
        if (pos == 14) begin
            is_rd    = (sh[13:10] == 4'b0110) || (sh[13:10] == 4'b0011);
            rsp_data = phy_val(sh[9:5], sh[4:0]);
        end
        if (pos == 32) begin
            if (sb.size() == 0) begin
                check(0, "R6", "unexpected frame", sh, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(sh == e.body, e.req, "frame body", sh, e.body);
                check(ones == e.ones, "R9", "preamble ones", ones, e.ones);
                check(!oe_bad, "R10", "output enable pattern", {31'd0, oe_bad}, 32'd0);
            end
            pos = 0; ones = 0; is_rd = 0; oe_bad = 0;
        end
    end

    always @(negedge mdc) begin
        logic [3:0] bi;
        bi     = 4'(31 - pos);
        phy_oe <= rsp_en && is_rd && pos >= 15 && pos <= 31;
        phy_o  <= (pos == 15) ? 1'b0 : rsp_data[bi];
    end

    // Driver tasks
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic expect_frame(input string req, input int n_ones, input logic [31:0] b);
        exp_t e;
        e.req = req; e.ones = n_ones; e.body = b;
        sb.push_back(e);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd(2'd0, v);
            n++;
        end while (v[0] && n < 4000);
        check(!v[0], req, "busy never cleared", v, 32'h0);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int hi, lo;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check(v == 32'h280, "R1", "reset status", v, 32'h280);
        rd(2'd1, v); check(v == 32'h0, "R1", "reset control", v, 32'h0);
        rd(2'd2, v); check(v == 32'h0, "R1", "reset data", v, 32'h0);
        rd(2'd3, v); check(v == 32'h0, "R1", "reset address", v, 32'h0);

        // R1 control without read command: stored, no frame
        wr(2'd1, 32'hFFFF_7C69);
        rd(2'd1, v); check(v == 32'h69, "R1", "control readback", v, 32'h69);
        rd(2'd0, v); check(v == 32'h280, "R1", "no busy after plain control", v, 32'h280);

        // R2 Clause 22 write, R6 busy and ignored writes
        expect_frame("R2", 32, body(0, 2'b01, 5'd3, 5'd9, 2'b10, 16'hBEEF));
        wr(2'd2, 32'h0000_BEEF);
        rd(2'd0, v); check(v[0] == 1'b1, "R6", "busy during frame", v, 32'h281);
        wr(2'd1, 32'h0000_03FF);
        wr(2'd0, 32'h0000_00E0);
        wait_idle("R6");
        rd(2'd1, v); check(v == 32'h69, "R6", "control write while busy ignored", v, 32'h69);
        rd(2'd0, v); check(v == 32'h280, "R6", "status write while busy ignored", v, 32'h280);
        rd(2'd2, v); check(v == 32'hBEEF, "R1", "data readback", v, 32'hBEEF);

        // R3 Clause 22 read
        expect_frame("R3", 32, body(0, 2'b10, 5'd5, 5'd2, 2'b10, phy_val(5'd5, 5'd2)));
        wr(2'd1, 32'h0000_80A2);
        wait_idle("R3");
        rd(2'd2, v); check(v == 32'(phy_val(5'd5, 5'd2)), "R3", "read data", v, 32'(phy_val(5'd5, 5'd2)));
        rd(2'd0, v); check(v == 32'h280, "R7", "no error with PHY present", v, 32'h280);
        rd(2'd1, v); check(v == 32'hA2, "R1", "read command bit reads 0", v, 32'hA2);

        // R4, R5 Clause 45
        wr(2'd0, 32'h0000_02C0);
        wr(2'd1, 32'h0000_00E1);
        expect_frame("R4", 32, body(1, 2'b00, 5'd7, 5'd1, 2'b10, 16'h1234));
        wr(2'd3, 32'h0000_1234);
        wait_idle("R4");
        expect_frame("R5", 32, body(1, 2'b01, 5'd7, 5'd1, 2'b10, 16'h0F0F));
        wr(2'd2, 32'h0000_0F0F);
        wait_idle("R5");
        expect_frame("R5", 32, body(1, 2'b11, 5'd7, 5'd1, 2'b10, phy_val(5'd7, 5'd1)));
        wr(2'd1, 32'h0000_80E1);
        wait_idle("R5");
        rd(2'd2, v); check(v == 32'(phy_val(5'd7, 5'd1)), "R5", "c45 read data", v, 32'(phy_val(5'd7, 5'd1)));

        // R9 preamble disabled
        wr(2'd0, 32'h0000_02E0);
        rd(2'd0, v); check(v == 32'h2E0, "R1", "status readback", v, 32'h2E0);
        expect_frame("R9", 0, body(1, 2'b01, 5'd7, 5'd1, 2'b10, 16'h00AA));
        wr(2'd2, 32'h0000_00AA);
        wait_idle("R9");
        wr(2'd0, 32'h0000_02A0);
        expect_frame("R9", 0, body(0, 2'b10, 5'd4, 5'd31, 2'b10, phy_val(5'd4, 5'd31)));
        wr(2'd1, 32'h0000_809F);
        wait_idle("R9");
        rd(2'd2, v); check(v == 32'(phy_val(5'd4, 5'd31)), "R9", "read data no preamble", v, 32'(phy_val(5'd4, 5'd31)));

        // R4 address write in Clause 22 mode
        wr(2'd0, 32'h0000_0280);
        wr(2'd3, 32'h0000_5555);
        repeat (30) @(negedge clk);
        rd(2'd0, v); check(v == 32'h280, "R4", "no frame on c22 address write", v, 32'h280);
        rd(2'd3, v); check(v == 32'h5555, "R4", "address stored", v, 32'h5555);

        // R7 absent PHY
        rsp_en = 1'b0;
        expect_frame("R7", 32, body(0, 2'b10, 5'd9, 5'd3, 2'b11, 16'hFFFF));
        wr(2'd1, 32'h0000_8123);
        wait_idle("R7");
        rd(2'd0, v); check(v == 32'h282, "R7", "read error flag", v, 32'h282);
        rd(2'd2, v); check(v == 32'hFFFF, "R7", "absent PHY data", v, 32'hFFFF);
        rsp_en = 1'b1;
        expect_frame("R2", 32, body(0, 2'b01, 5'd9, 5'd3, 2'b10, 16'h1357));
        wr(2'd2, 32'h0000_1357);
        rd(2'd0, v); check(v == 32'h281, "R7", "error cleared at next start", v, 32'h281);
        wait_idle("R7");

        // R8 divider 7: period 15, high 7
        wr(2'd0, 32'h0000_0380);
        expect_frame("R8", 32, body(0, 2'b01, 5'd9, 5'd3, 2'b10, 16'h2468));
        wr(2'd2, 32'h0000_2468);
        @(posedge mdc);
        hi = 0; lo = 0;
        @(negedge clk);
        while (mdc) begin hi++; @(negedge clk); end
        while (!mdc) begin lo++; @(negedge clk); end
        check(hi == 7, "R8", "mdc high phase", hi, 7);
        check(hi + lo == 15, "R8", "mdc period", hi + lo, 15);
        wait_idle("R8");
        check(mdc == 1'b0, "R8", "mdc low when idle", {31'd0, mdc}, 32'h0);

        check(sb.size() == 0, "R6", "frames missing", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule